// File: doc/BRIEF.md
# Nested priority interrupt arbiter

This block decides which interrupt the processor takes next when interrupts can nest. Up to 16 peripheral vectors each carry a 2-bit software level. A vector position gives each one a fixed hardware rank. The arbiter compares every pending and enabled request with the level the processor is running at now, which is held as two condition-code bits. It keeps only the requests whose level is strictly higher than that current level. From those it picks one winner. It reports the winner's vector number and the level code that the processor must load into its condition code, so that requests at the new level and below are masked.

Two system sources sit above all peripherals and ignore the level bits: a software trap and a non-maskable request. Arbitration is combinational. The result is captured only on the instruction-boundary strobe, and the take strobe is a one-cycle pulse. Saving the context and sequencing the processor are handled elsewhere. The restored level after a return simply reappears on the current-level input.

Top module: `nest_irq_arb`

## Requirements
- R1: A 2-bit level code maps to a level as follows: code 2'b10 is level 0 (lowest), 2'b01 is level 1, 2'b00 is level 2 and 2'b11 is level 3 (highest, interrupts disabled). The current-level input and each vector's code in `lvl_cfg[2*i+1:2*i]` use this mapping.
- R2: Peripheral vector i is a candidate only when both `evt_flag[i]` and `evt_en[i]` are 1.
- R3: A candidate is taken only if its level is strictly greater than the current level. A request at the same level or below is ignored, so a current code of 2'b11 blocks every peripheral and a level-0 request is never taken.
- R4: Among the qualifying candidates, the one with the highest level wins, whatever its vector position.
- R5: Among qualifying candidates at the same highest level, the lowest vector index wins.
- R6: A software trap (`trap_req`) is always taken at a boundary, before any other source, with `vec_id` 0 and `new_code` 2'b11.
- R7: A non-maskable request (`nmi_req`) with no trap is always taken at a boundary, at any current level and before any peripheral, with `vec_id` 1 and `new_code` 2'b11.
- R8: The outputs are captured only on a clock edge where `boundary` is 1. `take` is 1 for exactly the one cycle after such an edge, and only if some source won.
- R9: When `take` is 0, `vec_id` and `new_code` keep their last values.
- R10: After reset, `take` is 0, `vec_id` is 0 and `new_code` is 2'b11.
- R11: A peripheral winner at index i gives `vec_id` = i+2 and `new_code` equal to that vector's own configured level code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| boundary | input | 1 | Instruction-boundary strobe; the arbitration result is captured here |
| trap_req | input | 1 | Software trap request |
| nmi_req | input | 1 | Non-maskable request |
| evt_flag | input | N_VEC | Peripheral status flags |
| evt_en | input | N_VEC | Peripheral enable bits |
| lvl_cfg | input | 2*N_VEC | Per-vector software level codes |
| cur_code | input | 2 | Current level code from the condition code |
| take | output | 1 | One-cycle pulse: an interrupt is to be taken |
| vec_id | output | $clog2(N_VEC+2) | Vector number: 0 for the trap, 1 for the NMI, i+2 for peripheral i |
| new_code | output | 2 | Level code to load into the condition code |

## Verification
The assertions check the following on every cycle:
- `take` only follows a boundary edge.
- The outputs are held while `take` is 0.
- A trap or NMI at a boundary always produces its own vector and code 2'b11.
- A taken peripheral was pending and enabled, and its new level is strictly above the level current at capture.

Whether the chosen peripheral is the right one — highest level first, then the lowest index — can only be shown by the bench. The bench computes the expected winner for swept and pseudo-random sets of flags, enables, codes and current levels.

// File: rtl/nia_pkg.sv
package nia_pkg;

  // level code <-> numeric level (0 lowest .. 3 highest / disabled)
  function automatic logic [1:0] code2lvl(input logic [1:0] c);
    case (c)
      2'b10:   code2lvl = 2'd0;
      2'b01:   code2lvl = 2'd1;
      2'b00:   code2lvl = 2'd2;
      default: code2lvl = 2'd3;
    endcase
  endfunction

  function automatic logic [1:0] lvl2code(input logic [1:0] l);
    case (l)
      2'd0:    lvl2code = 2'b10;
      2'd1:    lvl2code = 2'b01;
      2'd2:    lvl2code = 2'b00;
      default: lvl2code = 2'b11;
    endcase
  endfunction

  localparam logic [1:0] CODE_MASKED = 2'b11;

endpackage

// File: rtl/nia_req_qual.sv
module nia_req_qual #(
  parameter int N_VEC = 16
) (
  input  logic [N_VEC-1:0]   evt_flag,
  input  logic [N_VEC-1:0]   evt_en,
  input  logic [2*N_VEC-1:0] lvl_cfg,
  input  logic [1:0]         cur_code,
  output logic [N_VEC-1:0]   elig,
  output logic [2*N_VEC-1:0] lvl_num
);
  import nia_pkg::*;

  logic [1:0] cur_lvl;
  assign cur_lvl = code2lvl(cur_code);

  for (genvar i = 0; i < N_VEC; i++) begin : g_vec
    logic [1:0] my_lvl;
    assign my_lvl               = code2lvl(lvl_cfg[2*i +: 2]);
    assign lvl_num[2*i +: 2]    = my_lvl;
    assign elig[i]              = evt_flag[i] & evt_en[i] & (my_lvl > cur_lvl);
  end

endmodule

// File: rtl/nia_pick.sv
module nia_pick #(
  parameter int N_VEC = 16,
  parameter int IW    = (N_VEC > 1) ? $clog2(N_VEC) : 1
) (
  input  logic [N_VEC-1:0]   elig,
  input  logic [2*N_VEC-1:0] lvl_num,
  output logic               any,
  output logic [IW-1:0]      idx,
  output logic [1:0]         lvl
);
  // highest level wins; strict compare keeps the lowest index on ties
  always_comb begin
    any = 1'b0;
    idx = '0;
    lvl = 2'd0;
    for (int i = 0; i < N_VEC; i++) begin
      if (elig[i] && (!any || (lvl_num[2*i +: 2] > lvl))) begin
        any = 1'b1;
        idx = IW'(i);
        lvl = lvl_num[2*i +: 2];
      end
    end
  end

endmodule

// File: rtl/nest_irq_arb.sv
module nest_irq_arb #(
  parameter int N_VEC = 16,
  localparam int IW   = (N_VEC > 1) ? $clog2(N_VEC) : 1,
  localparam int VIW  = $clog2(N_VEC + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary,
  input  logic               trap_req,
  input  logic               nmi_req,
  input  logic [N_VEC-1:0]   evt_flag,
  input  logic [N_VEC-1:0]   evt_en,
  input  logic [2*N_VEC-1:0] lvl_cfg,
  input  logic [1:0]         cur_code,
  output logic               take,
  output logic [VIW-1:0]     vec_id,
  output logic [1:0]         new_code
);
  import nia_pkg::*;

  localparam logic [VIW-1:0] V_TRAP = VIW'(0);
  localparam logic [VIW-1:0] V_NMI  = VIW'(1);
  localparam logic [VIW-1:0] V_BASE = VIW'(2);

  logic [N_VEC-1:0]   elig;
  logic [2*N_VEC-1:0] lvl_num;
  logic               win_any;
  logic [IW-1:0]      win_idx;
  logic [1:0]         win_lvl;
  logic               sys_hit;
  logic               fire;
  logic [VIW-1:0]     nxt_vec;
  logic [1:0]         nxt_code;

  nia_req_qual #(.N_VEC(N_VEC)) u_qual (
    .evt_flag (evt_flag),
    .evt_en   (evt_en),
    .lvl_cfg  (lvl_cfg),
    .cur_code (cur_code),
    .elig     (elig),
    .lvl_num  (lvl_num)
  );

  nia_pick #(.N_VEC(N_VEC), .IW(IW)) u_pick (
    .elig    (elig),
    .lvl_num (lvl_num),
    .any     (win_any),
    .idx     (win_idx),
    .lvl     (win_lvl)
  );

  assign sys_hit = trap_req | nmi_req;
  assign fire    = sys_hit | win_any;

  always_comb begin
    if (trap_req) begin
      nxt_vec  = V_TRAP;
      nxt_code = CODE_MASKED;
    end else if (nmi_req) begin
      nxt_vec  = V_NMI;
      nxt_code = CODE_MASKED;
    end else begin
      nxt_vec  = VIW'(win_idx) + V_BASE;
      nxt_code = lvl2code(win_lvl);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take     <= 1'b0;
      vec_id   <= '0;
      new_code <= CODE_MASKED;
    end else begin
      take <= boundary & fire;
      if (boundary && fire) begin
        vec_id   <= nxt_vec;
        new_code <= nxt_code;
      end
    end
  end

endmodule

// File: rtl/nia_chk.sv
module nia_chk #(
  parameter int N_VEC = 16,
  localparam int VIW  = $clog2(N_VEC + 2)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               boundary,
  input logic               trap_req,
  input logic               nmi_req,
  input logic [N_VEC-1:0]   evt_flag,
  input logic [N_VEC-1:0]   evt_en,
  input logic [1:0]         cur_code,
  input logic               take,
  input logic [VIW-1:0]     vec_id,
  input logic [1:0]         new_code
);
  import nia_pkg::*;

  logic [N_VEC-1:0] req_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= evt_flag & evt_en;
  end

  a_r8_take_after_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(boundary));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> ($stable(vec_id) && $stable(new_code)));

  a_r6_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && trap_req) |=> (take && vec_id == VIW'(0) && new_code == 2'b11));

  a_r7_nmi_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && nmi_req && !trap_req) |=> (take && vec_id == VIW'(1) && new_code == 2'b11));

  a_r3_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_id >= VIW'(2)) |-> (code2lvl(new_code) > code2lvl($past(cur_code))));

  a_r2_pending_and_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (take && vec_id >= VIW'(2)) |-> req_q[int'(vec_id) - 2]);

  a_r10_reset_values: assert property (@(posedge clk)
    !rst_n |=> (!take && vec_id == '0 && new_code == 2'b11));

endmodule

bind nest_irq_arb nia_chk #(.N_VEC(N_VEC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .boundary (boundary),
  .trap_req (trap_req),
  .nmi_req  (nmi_req),
  .evt_flag (evt_flag),
  .evt_en   (evt_en),
  .cur_code (cur_code),
  .take     (take),
  .vec_id   (vec_id),
  .new_code (new_code)
);

// File: tb/sim_nest_irq_arb.sv
`timescale 1ns/1ps
module sim_nest_irq_arb;
  localparam int N   = 16;
  localparam int VIW = $clog2(N + 2);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           boundary = 1'b0, trap_req = 1'b0, nmi_req = 1'b0;
  logic [N-1:0]   evt_flag = '0, evt_en = '0;
  logic [2*N-1:0] lvl_cfg = '0;
  logic [1:0]     cur_code = 2'b10;
  logic           take;
  logic [VIW-1:0] vec_id;
  logic [1:0]     new_code;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [VIW-1:0] h_vec  = '0;
  logic [1:0]     h_code = 2'b11;
  logic [31:0]    rs = 32'h1234_5678;

  always #5 clk = ~clk;

  nest_irq_arb #(.N_VEC(N)) u0 (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .trap_req(trap_req),
    .nmi_req(nmi_req), .evt_flag(evt_flag), .evt_en(evt_en), .lvl_cfg(lvl_cfg),
    .cur_code(cur_code), .take(take), .vec_id(vec_id), .new_code(new_code));

  function automatic int dec(input logic [1:0] c);
    return (c == 2'b10) ? 0 : (c == 2'b01) ? 1 : (c == 2'b00) ? 2 : 3;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] v);
    logic [31:0] t = v;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  task automatic cmp(input string tag, input logic et, input logic [VIW-1:0] ev,
                     input logic [1:0] ec);
    n_cmp++;
    if (take !== et || vec_id !== ev || new_code !== ec) begin
      n_bad++;
      $display("FAIL %s: take/vec/code = %0b/%0d/%b expected %0b/%0d/%b",
               tag, take, vec_id, new_code, et, ev, ec);
    end
  endtask

  // one clock of stimulus, then compare after the capturing edge
  task automatic apply(input string tag, input logic [N-1:0] f, input logic [N-1:0] e,
                       input logic [2*N-1:0] l, input logic [1:0] c,
                       input logic t, input logic n, input logic b);
    logic et = 1'b0;
    @(negedge clk);
    evt_flag = f; evt_en = e; lvl_cfg = l; cur_code = c;
    trap_req = t; nmi_req = n; boundary = b;
    if (b) begin
      if (t) begin et = 1; h_vec = VIW'(0); h_code = 2'b11; end
      else if (n) begin et = 1; h_vec = VIW'(1); h_code = 2'b11; end
      else begin
        for (int lv = 3; lv >= 1; lv--) begin
          if (!et && lv > dec(c)) begin
            for (int i = 0; i < N; i++) begin
              if (!et && f[i] && e[i] && dec(l[2*i +: 2]) == lv) begin
                et = 1; h_vec = VIW'(i + 2); h_code = l[2*i +: 2];
              end
            end
          end
        end
      end
    end
    @(negedge clk);
    cmp(tag, et, h_vec, h_code);
  endtask

  function automatic logic [2*N-1:0] one_lvl(input int i, input logic [1:0] c,
                                              input logic [2*N-1:0] base);
    logic [2*N-1:0] r = base;
    r[2*i +: 2] = c;
    return r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    cmp("R10 reset", 1'b0, '0, 2'b11);

    // R1: every code on vector 5 against level 0
    apply("R1 code 01", 16'h0020, 16'h0020, one_lvl(5, 2'b01, '0), 2'b10, 0, 0, 1);
    apply("R1 code 00", 16'h0020, 16'h0020, one_lvl(5, 2'b00, '0), 2'b10, 0, 0, 1);
    apply("R1 code 11", 16'h0020, 16'h0020, one_lvl(5, 2'b11, '0), 2'b10, 0, 0, 1);
    apply("R1 code 10 never", 16'h0020, 16'h0020, one_lvl(5, 2'b10, {N{2'b10}}), 2'b10, 0, 0, 1);
    // R2: flag or enable alone
    apply("R2 flag only", 16'h0100, 16'h0000, {N{2'b11}}, 2'b10, 0, 0, 1);
    apply("R2 enable only", 16'h0000, 16'h0100, {N{2'b11}}, 2'b10, 0, 0, 1);
    // R3: equal level and fully masked
    apply("R3 equal level", 16'h0008, 16'hFFFF, {N{2'b01}}, 2'b01, 0, 0, 1);
    apply("R3 masked 11", 16'hFFFF, 16'hFFFF, {N{2'b11}}, 2'b11, 0, 0, 1);
    apply("R3 above current", 16'h0008, 16'hFFFF, {N{2'b00}}, 2'b01, 0, 0, 1);
    // R4: higher level beats lower index
    apply("R4 level first", 16'h1004, 16'hFFFF,
          one_lvl(12, 2'b11, one_lvl(2, 2'b01, '0)), 2'b10, 0, 0, 1);
    // R5: tie on level, lowest index
    apply("R5 tie", 16'h0208, 16'hFFFF, {N{2'b00}}, 2'b10, 0, 0, 1);
    apply("R5 tie top", 16'hC000, 16'hFFFF, {N{2'b00}}, 2'b01, 0, 0, 1);
    // R6 / R7
    apply("R6 trap", 16'hFFFF, 16'hFFFF, {N{2'b11}}, 2'b11, 1, 1, 1);
    apply("R7 nmi masked level", 16'hFFFF, 16'hFFFF, {N{2'b11}}, 2'b11, 0, 1, 1);
    apply("R7 nmi over periph", 16'hFFFF, 16'hFFFF, {N{2'b11}}, 2'b10, 0, 1, 1);
    // R8 / R9: no boundary -> no capture, values hold
    apply("R8 no boundary", 16'h0001, 16'h0001, {N{2'b00}}, 2'b10, 0, 0, 0);
    apply("R9 hold no boundary trap", 16'h0, 16'h0, '0, 2'b10, 1, 0, 0);
    apply("R11 index 15", 16'h8000, 16'h8000, one_lvl(15, 2'b01, '0), 2'b10, 0, 0, 1);
    apply("R9 hold no winner", 16'h0, 16'hFFFF, '0, 2'b10, 0, 0, 1);
    apply("R11 index 0", 16'h0001, 16'h0001, {N{2'b00}}, 2'b10, 0, 0, 1);

    // R4 R5 R11 sweep: pseudo-random sets, all current levels
    for (int k = 0; k < 800; k++) begin
      logic [N-1:0] f, e;
      logic [2*N-1:0] l;
      rs = nxt(rs); f = rs[N-1:0]; e = rs[31:32-N];
      rs = nxt(rs); l = rs;
      rs = nxt(rs);
      apply("R11 sweep", f, e, l, 2'(k % 4), rs[7:0] == 8'h00, rs[15:8] == 8'h01,
            rs[18:16] != 3'b000);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule